// File: doc/BRIEF.md
# Prescaled Compare Timer with Capture

An 8-bit up-counting timer that paces itself from one of seven power-of-two
taps of a free-running prescaler, or from the rising edges of an external
input. In interval mode the counter is checked against a compare register on
every count. When the next count would equal the compare value, the counter
returns to zero and a one-cycle interrupt pulse is raised. In capture mode the
compare register is ignored and the counter wraps freely. A rising edge on the
external input then latches the live count into a capture register and raises
the interrupt.

Software sets the block up through a small register port: a control byte, a
compare byte and a read-only capture byte. Setting the auto-capture bit while
in interval or event mode copies the running count into the capture register
on every clock, so software can sample the count without stopping it. A
capture taken while the counter is rolling over may be stale by one count, and
software must allow for this. Clearing the run bit stops the counter and holds
it at zero.

Top module: `cmp_timer8`

## Requirements
- R1: After reset the control, compare and capture registers read 0x00 and `irq` is low.
- R2: While the run bit (control bit 3) is 0, the counter is held at zero and no interrupt is raised. With auto-capture on, the capture register then reads 0x00.
- R3: In interval mode (control bit 5 = 0) with clock select S (control bits 2:0) in 0..6 and compare value N in 1..255, interrupts repeat every N·2^(13−S) clock cycles while `ce` is held high.
- R4: A compare value of 0x00 raises the interrupt once every 256 counts, on the 255-to-0 wrap.
- R5: Clock select 7 counts synchronised rising edges of `ext_in`. With compare value N, the interrupt comes on the Nth edge after the run bit is set and on no earlier edge. This holds up to N = 255.
- R6: In capture mode (control bit 5 = 1) each rising edge of `ext_in` copies the live count into the capture register and pulses `irq`. The counter is not cleared and the compare register has no effect. The capture register holds its value between edges.
- R7: With auto-capture (control bit 4 = 1) outside capture mode, reads of the capture register follow the running count.
- R8: `irq` is never high on two consecutive clock cycles.
- R9: Register reads use `rd_addr` 0 = control, 1 = compare, 2 = capture. `rd_data` is registered and shows the addressed register one cycle after the address is applied. The control byte reads back all 8 bits as written.
- R10: A write to the compare register takes effect on the next count, without stopping the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable from the free-running prescaler source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 compare) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 compare, 2 capture) |
| rd_data | output | 8 | Registered read data |
| ext_in | input | 1 | External event / capture input (asynchronous) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Interval mode is driven from a table of clock-select and compare pairs, which
covers the slowest and fastest taps and compare values of 1 and larger. Each
measured interrupt period tells apart an off-by-one in the compare, a wrong
tap and a wrong match rule. Event mode is driven with trains of 255 and 256
edges, which separates the largest compare value from the zero-means-wrap case
and shows that no interrupt arrives early. Capture mode takes two edges exactly
five counts apart with a compare value small enough that a wrongful clear
would show in the count. Auto-capture reads spaced two counts apart, and a
compare rewrite made while the counter runs, confirm the live sampling and
that a new compare value is used at once.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;
  localparam int ADDR_W = 2;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 2'd2;

  localparam logic [2:0] SEL_EXT = 3'b111;

  typedef struct packed {
    logic [1:0] spare;
    logic       capmode;
    logic       autocap;
    logic       run;
    logic [2:0] sel;
  } ctrl_t;
endpackage

// File: rtl/cmp_timer8_presc.sv
module cmp_timer8_presc #(
  parameter int PRE_W    = 13,
  parameter int NUM_TAPS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int SEL_N = 8;

  logic [PRE_W-1:0]    pre_q;
  logic [NUM_TAPS-1:0] taps;
  logic [SEL_N-1:0]    tapv;

  always_ff @(posedge clk) begin
    if (rst)     pre_q <= '0;
    else if (ce) pre_q <= pre_q + 1'b1;
  end

  // tap k fires once every 2^(PRE_W-k) enabled cycles
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign taps[k] = ce && (&pre_q[PRE_W-1-k:0]);
  end

  assign tapv = {{(SEL_N-NUM_TAPS){1'b0}}, taps};

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= tapv[sel];
  end

  // slower taps are nested inside the fastest one (R3)
  p_tap_nest_r3: assert property (@(posedge clk) disable iff (rst)
    taps[0] |-> taps[NUM_TAPS-1]);
endmodule

// File: rtl/cmp_timer8_edge.sv
module cmp_timer8_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      rise <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC_N-1:0], ext_in};
      rise <= sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    end
  end

  // an edge strobe never lasts two cycles (R5)
  p_rise_gap_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cmp_timer8_core.sv
module cmp_timer8_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             capmode,
  input  logic             autocap,
  input  logic             sel_ext,
  input  logic [CNT_W-1:0] cmp,
  input  logic             tap_tick,
  input  logic             ext_rise,
  output logic [CNT_W-1:0] cap,
  output logic             irq
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] nxt;
  logic             tick;

  assign tick = sel_ext ? ext_rise : tap_tick;
  assign nxt  = count_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      cap     <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!run) begin
        count_q <= '0;
      end else begin
        if (tick) begin
          if (!capmode && nxt == cmp) begin
            count_q <= '0;
            irq     <= 1'b1;
          end else begin
            count_q <= nxt;
          end
        end
        if (capmode && ext_rise) begin
          cap <= count_q;
          irq <= 1'b1;
        end
      end
      if (!capmode && autocap) cap <= count_q;
    end
  end

  // interrupt is a single-cycle pulse (R8)
  p_irq_one_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // a compare interrupt leaves the counter at zero (R3)
  p_clear_on_match_r3: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(capmode)) |-> (count_q == '0));

  // stopped counter is zero and silent (R2)
  p_stop_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count_q == '0 && !irq));

  // capture register only moves on an edge in capture mode (R6)
  p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (capmode && !ext_rise) |=> $stable(cap));
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import cmp_timer8_pkg::*;
#(
  parameter int PRE_W    = 13,
  parameter int NUM_TAPS = 7,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ext_in,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] cmp_q;
  logic [REG_W-1:0] cap;
  logic             tap_tick;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data);
      if (wr_addr == A_CMP)  cmp_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= ctrl_q;
        A_CMP:   rd_data <= cmp_q;
        A_CAP:   rd_data <= cap;
        default: rd_data <= '0;
      endcase
    end
  end

  cmp_timer8_presc #(.PRE_W(PRE_W), .NUM_TAPS(NUM_TAPS)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .ce   (ce),
    .sel  (ctrl_q.sel),
    .tick (tap_tick)
  );

  cmp_timer8_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .ext_in (ext_in),
    .rise   (ext_rise)
  );

  cmp_timer8_core #(.CNT_W(REG_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q.run),
    .capmode  (ctrl_q.capmode),
    .autocap  (ctrl_q.autocap),
    .sel_ext  (ctrl_q.sel == SEL_EXT),
    .cmp      (cmp_q),
    .tap_tick (tap_tick),
    .ext_rise (ext_rise),
    .cap      (cap),
    .irq      (irq)
  );

  // read data follows the addressed compare register one cycle later (R9)
  p_rd_cmp_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CMP && $past(!rst)) |-> (rd_data == $past(cmp_q)));
endmodule

// File: tb/cmp_timer8_tb.sv
module cmp_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_total = 0;
  int r8_bad = 0;
  logic prev_irq = 1'b0;

  always #5 clk = ~clk;

  cmp_timer8 dut_i (
    .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_in(ext_in), .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq) irq_total <= irq_total + 1;
    if (irq && prev_irq) r8_bad <= r8_bad + 1;
    prev_irq <= irq;
  end

  localparam int NV = 6;
  localparam int VSEL[NV] = '{6, 6, 5, 4, 3, 0};
  localparam int VCMP[NV] = '{3, 1, 2, 1, 5, 1};
  localparam int VPER[NV] = '{384, 128, 512, 512, 5120, 8192};

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < limit);
  endtask

  task automatic pulse();
    @(negedge clk); ext_in = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk); ext_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    int v, v1, v2, n, base, t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    rd(2'd0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); check(v == 0, "R1 cmp", v, 0);
    rd(2'd2, v); check(v == 0, "R1 cap", v, 0);

    // R9 readback
    wr(2'd1, 8'h5A); rd(2'd1, v); check(v == 8'h5A, "R9 cmp readback", v, 8'h5A);
    wr(2'd0, 8'hC0); rd(2'd0, v); check(v == 8'hC0, "R9 ctrl readback", v, 8'hC0);

    // R3 interval table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'h00);
      wr(2'd1, 8'(VCMP[i]));
      wr(2'd0, 8'h08 | 8'(VSEL[i]));
      wait_irq(20000, n);
      wait_irq(20000, n);
      check(n == VPER[i], $sformatf("R3 period sel=%0d cmp=%0d", VSEL[i], VCMP[i]), n, VPER[i]);
    end

    // R5 event mode, compare 255
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF); wr(2'd0, 8'h0F);
    settle(); base = irq_total;
    for (int e = 0; e < 254; e++) pulse();
    settle(); check(irq_total == base, "R5 no early irq (255)", irq_total - base, 0);
    pulse(); settle();
    check(irq_total == base + 1, "R5 irq on 255th edge", irq_total - base, 1);

    // R4 compare 0 wraps after 256 counts
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h0F);
    settle(); base = irq_total;
    for (int e = 0; e < 255; e++) pulse();
    settle(); check(irq_total == base, "R4 no irq before wrap", irq_total - base, 0);
    pulse(); settle();
    check(irq_total == base + 1, "R4 irq on wrap", irq_total - base, 1);

    // R6 capture mode, compare 2 must be ignored
    wr(2'd0, 8'h00); wr(2'd1, 8'h02); wr(2'd0, 8'h2E);
    t0 = cyc;
    wait_until(t0 + 1300);
    base = irq_total;
    t0 = cyc;
    pulse(); settle();
    check(irq_total == base + 1, "R6 irq on capture", irq_total - base, 1);
    rd(2'd2, v1);
    check(v1 >= 9 && v1 <= 11, "R6 count not cleared", v1, 10);
    repeat (200) @(negedge clk);
    rd(2'd2, v); check(v == v1, "R6 capture holds", v, v1);
    wait_until(t0 + 640);
    pulse(); settle();
    rd(2'd2, v2);
    check(((v2 - v1) & 255) == 5, "R6 capture delta", (v2 - v1) & 255, 5);

    // R2 stopped counter with auto-capture
    wr(2'd0, 8'h16);
    settle(); base = irq_total;
    repeat (2000) @(negedge clk);
    #1; check(irq_total == base, "R2 no irq while stopped", irq_total - base, 0);
    rd(2'd2, v); check(v == 0, "R2 count held zero", v, 0);

    // R7 auto-capture follows live count
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h1E);
    t0 = cyc;
    wait_until(t0 + 1280);
    rd(2'd2, v1);
    check(v1 >= 9 && v1 <= 11, "R7 live count", v1, 10);
    wait_until(t0 + 1280 + 256);
    rd(2'd2, v2);
    check(v2 - v1 == 2, "R7 count advance", v2 - v1, 2);

    // R10 compare rewrite takes effect at once (count ~12 now)
    wr(2'd1, 8'd20);
    wait_irq(5000, n);
    check(irq == 1'b1 && n < 1500, "R10 early match after rewrite", n, 1100);
    wait_irq(5000, n);
    check(n == 2560, "R10 new period", n, 2560);

    // R8 pulse width over the whole run
    check(r8_bad == 0, "R8 single-cycle irq", r8_bad, 0);

    finish_up();
  end
endmodule